// File: doc/BRIEF.md
# Transition count response compactor

This block condenses a serial stream of single-bit memory read results, as produced by a pattern-sensitive-fault memory test, into three counts that are kept side by side. The first is the number of reads that returned one. The second is the number of rising pairs, where a read of 0 is followed by a read of 1. The third is the number of toggling pairs, where a read differs from the one before it. Each count catches a different class of corrupted stream, so a wrong response that leaves one count unchanged is still exposed by the others. For example, 0011 and 1100 have the same number of ones but different rising counts. 1100 and 0011 have the same toggling count, while 1010 does not.

A test controller clears the block, then presents each read bit with a valid strobe. At the end of the test it pulses a finish strobe while it drives the three expected counts. The block registers a single match flag from that comparison. Counts saturate rather than wrap, so a very long faulty stream cannot alias back onto the expected value.

Top module: `resp_tally`

## Requirements
- R1: While `rst_ni` is low, and on the cycle after a `clear_i` pulse, all three counts are 0 and `match_o` is 0.
- R2: Each cycle with `valid_i` high adds 1 to `ones_o` when `bit_i` is 1. A valid bit of 0 leaves `ones_o` unchanged.
- R3: `rise_o` increments once for each pair of consecutive valid bits where the earlier bit is 0 and the later bit is 1.
- R4: `toggle_o` increments once for each pair of consecutive valid bits whose values differ, in either direction.
- R5: The first valid bit after reset or clear has no predecessor. It never adds to `rise_o` or `toggle_o`.
- R6: Each count stops at 2^CNT_W-1 and holds there. It never wraps to 0.
- R7: On a cycle with `finish_i` high, `match_o` is registered as 1 when all three counts equal `exp_ones_i`, `exp_rise_i` and `exp_toggle_i`, and as 0 otherwise. The comparison uses the counts held before that cycle. Without `finish_i` or `clear_i`, `match_o` holds its value.
- R8: A cycle with `valid_i` low leaves all counts and the stored previous bit unchanged, whatever `bit_i` is.
- R9: `clear_i` takes priority over `valid_i` and `finish_i` in the same cycle.
- R10: `rise_o` never exceeds `toggle_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous restart of the counts |
| valid_i | input | 1 | `bit_i` carries a read result this cycle |
| bit_i | input | 1 | Read result |
| finish_i | input | 1 | Evaluate the match against the expected counts |
| exp_ones_i | input | CNT_W | Expected ones count |
| exp_rise_i | input | CNT_W | Expected rising-pair count |
| exp_toggle_i | input | CNT_W | Expected toggling-pair count |
| ones_o | output | CNT_W | Ones count |
| rise_o | output | CNT_W | Rising-pair count |
| toggle_o | output | CNT_W | Toggling-pair count |
| match_o | output | 1 | All counts matched at the last finish |

## Verification
The bench builds the block with CNT_W = 3, so every count saturates at 7. With that width, streams of ten or more bits drive the ones count and the toggling count into saturation, and the bench confirms that they hold at 7 instead of wrapping. The four-bit streams 0011, 1100, 1010 and 0101 stay far below that limit. Each one is checked against the expected good triple (2,1,1), which shows which of the three counts separates it from the good stream.

// File: rtl/resp_tally_pkg.sv
package resp_tally_pkg;
  typedef enum int {
    CNT_ONES   = 0,
    CNT_RISE   = 1,
    CNT_TOGGLE = 2
  } cnt_kind_e;

  localparam int NUM_CNT = 3;
endpackage

// File: rtl/tally_sat_cnt.sv
module tally_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] MaxVal = {W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     q_o <= '0;
    else if (clr_i)                  q_o <= '0;
    else if (inc_i && q_o != MaxVal) q_o <= q_o + 1'b1;
  end
endmodule

// File: rtl/tally_pair_track.sv
module tally_pair_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic valid_i,
  input  logic bit_i,
  output logic rise_o,
  output logic diff_o
);
  logic prev_q, first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      first_q <= 1'b1;
    end else if (clr_i) begin
      prev_q  <= 1'b0;
      first_q <= 1'b1;
    end else if (valid_i) begin
      prev_q  <= bit_i;
      first_q <= 1'b0;
    end
  end

  // the first bit after clear has no predecessor
  assign rise_o = valid_i && !first_q && !prev_q && bit_i;
  assign diff_o = valid_i && !first_q && (prev_q != bit_i);
endmodule

// File: rtl/tally_match.sv
module tally_match #(
  parameter int W = 16,
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         eval_i,
  input  logic [W-1:0] cnt_i [N],
  input  logic [W-1:0] exp_i [N],
  output logic         match_o
);
  logic [N-1:0] eq;

  for (genvar g = 0; g < N; g++) begin : g_eq
    assign eq[g] = (cnt_i[g] == exp_i[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     match_o <= 1'b0;
    else if (clr_i)  match_o <= 1'b0;
    else if (eval_i) match_o <= &eq;
  end
endmodule

// File: rtl/resp_tally.sv
module resp_tally
  import resp_tally_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             valid_i,
  input  logic             bit_i,
  input  logic             finish_i,
  input  logic [CNT_W-1:0] exp_ones_i,
  input  logic [CNT_W-1:0] exp_rise_i,
  input  logic [CNT_W-1:0] exp_toggle_i,
  output logic [CNT_W-1:0] ones_o,
  output logic [CNT_W-1:0] rise_o,
  output logic [CNT_W-1:0] toggle_o,
  output logic             match_o
);
  logic [NUM_CNT-1:0] inc;
  logic [CNT_W-1:0]   cnt_q [NUM_CNT];
  logic [CNT_W-1:0]   exp_v [NUM_CNT];
  logic               rise_ev, diff_ev;

  tally_pair_track i_pair (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clear_i),
    .valid_i (valid_i),
    .bit_i   (bit_i),
    .rise_o  (rise_ev),
    .diff_o  (diff_ev)
  );

  assign inc[CNT_ONES]   = valid_i && bit_i;
  assign inc[CNT_RISE]   = rise_ev;
  assign inc[CNT_TOGGLE] = diff_ev;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    tally_sat_cnt #(.W(CNT_W)) i_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clear_i),
      .inc_i  (inc[g]),
      .q_o    (cnt_q[g])
    );
  end

  assign exp_v[CNT_ONES]   = exp_ones_i;
  assign exp_v[CNT_RISE]   = exp_rise_i;
  assign exp_v[CNT_TOGGLE] = exp_toggle_i;

  tally_match #(.W(CNT_W), .N(NUM_CNT)) i_match (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clear_i),
    .eval_i  (finish_i),
    .cnt_i   (cnt_q),
    .exp_i   (exp_v),
    .match_o (match_o)
  );

  assign ones_o   = cnt_q[CNT_ONES];
  assign rise_o   = cnt_q[CNT_RISE];
  assign toggle_o = cnt_q[CNT_TOGGLE];
endmodule

// File: rtl/resp_tally_chk.sv
module resp_tally_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic             valid_i,
  input logic             bit_i,
  input logic             finish_i,
  input logic [CNT_W-1:0] ones_o,
  input logic [CNT_W-1:0] rise_o,
  input logic [CNT_W-1:0] toggle_o,
  input logic             match_o
);
  localparam logic [CNT_W-1:0] MaxVal = {CNT_W{1'b1}};

  p_clear_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (ones_o == '0 && rise_o == '0 && toggle_o == '0 && !match_o));

  p_zero_no_ones_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && valid_i && !bit_i) |=> $stable(ones_o));

  p_no_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && ones_o == MaxVal) |=> ones_o == MaxVal);

  p_match_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !finish_i) |=> $stable(match_o));

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !valid_i) |=> ($stable(ones_o) && $stable(rise_o) && $stable(toggle_o)));

  p_rise_le_toggle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o <= toggle_o);
endmodule

bind resp_tally resp_tally_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clear_i  (clear_i),
  .valid_i  (valid_i),
  .bit_i    (bit_i),
  .finish_i (finish_i),
  .ones_o   (ones_o),
  .rise_o   (rise_o),
  .toggle_o (toggle_o),
  .match_o  (match_o)
);

// File: tb/test_resp_tally.sv
module test_resp_tally;
  localparam int W = 3;
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic clk = 1'b0, rst_ni = 1'b0;
  logic clear_i = 1'b0, valid_i = 1'b0, bit_i = 1'b0, finish_i = 1'b0;
  logic [W-1:0] exp_ones_i = '0, exp_rise_i = '0, exp_toggle_i = '0;
  logic [W-1:0] ones_o, rise_o, toggle_o;
  logic match_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  resp_tally #(.CNT_W(W)) i_resp_tally (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear_i), .valid_i(valid_i),
    .bit_i(bit_i), .finish_i(finish_i), .exp_ones_i(exp_ones_i),
    .exp_rise_i(exp_rise_i), .exp_toggle_i(exp_toggle_i),
    .ones_o(ones_o), .rise_o(rise_o), .toggle_o(toggle_o), .match_o(match_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk3(string req, int o, int r, int t);
    chk({req, " ones"}, ones_o, o);
    chk({req, " rise"}, rise_o, r);
    chk({req, " toggle"}, toggle_o, t);
  endtask

  task automatic do_clear();
    @(negedge clk); clear_i = 1'b1;
    @(negedge clk); clear_i = 1'b0;
  endtask

  task automatic push(logic b);
    @(negedge clk); valid_i = 1'b1; bit_i = b;
    @(negedge clk); valid_i = 1'b0;
  endtask

  task automatic push_str(string s);
    for (int i = 0; i < s.len(); i++) push(s[i] == "1");
  endtask

  task automatic finish(int o, int r, int t);
    @(negedge clk); finish_i = 1'b1;
    exp_ones_i = W'(o); exp_rise_i = W'(r); exp_toggle_i = W'(t);
    @(negedge clk); finish_i = 1'b0;
  endtask

  task automatic t_reset();
    chk3("R1 reset", 0, 0, 0);
    chk("R1 reset match", match_o, 0);
  endtask

  task automatic t_stream(string s, int o, int r, int t, int m);
    do_clear();
    push_str(s);
    chk3({"R2 R3 R4 stream ", s}, o, r, t);
    finish(2, 1, 1);
    chk({"R7 match ", s}, match_o, m);
  endtask

  task automatic t_first_bit();
    do_clear();
    push(1'b1);
    chk3("R5 first bit", 1, 0, 0);
  endtask

  task automatic t_idle();
    do_clear();
    push_str("01");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); bit_i = i[0];
    end
    chk3("R8 idle", 1, 1, 1);
    push(1'b1); // prev still 1: no transition
    chk3("R8 prev kept", 2, 1, 1);
  endtask

  task automatic t_saturate();
    do_clear();
    for (int i = 0; i < 10; i++) push(1'b1);
    chk3("R6 ones sat", 7, 0, 0);
    for (int i = 0; i < 10; i++) push(i[0] ? 1'b1 : 1'b0);
    chk("R6 ones hold", ones_o, MAXV);
    chk("R6 toggle sat", toggle_o, MAXV);
    chk("R10 rise le toggle", int'(rise_o <= toggle_o), 1);
    finish(7, int'(rise_o), 7);
    chk("R7 match sat", match_o, 1);
  endtask

  task automatic t_clear_prio();
    do_clear();
    push_str("011");
    finish(2, 1, 1);
    chk("R7 match pre", match_o, 1);
    @(negedge clk); clear_i = 1'b1; valid_i = 1'b1; bit_i = 1'b1; finish_i = 1'b1;
    @(negedge clk); clear_i = 1'b0; valid_i = 1'b0; finish_i = 1'b0;
    chk3("R9 clear prio", 0, 0, 0);
    chk("R9 clear match", match_o, 0);
    push(1'b0);
    chk3("R9 first after clear", 0, 0, 0);
  endtask

  task automatic t_match_hold();
    do_clear();
    push_str("0011");
    finish(2, 1, 1);
    push(1'b0);
    chk("R7 match held", match_o, 1);
    finish(2, 1, 1);
    chk("R7 match re-eval", match_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    t_stream("0011", 2, 1, 1, 1);
    t_stream("1100", 2, 0, 1, 0);
    t_stream("1010", 2, 1, 3, 0);
    t_stream("0101", 2, 2, 3, 0);
    t_first_bit();
    t_idle();
    t_saturate();
    t_clear_prio();
    t_match_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule